// File: doc/BRIEF.md
# CAN Bit Timing Resynchronization Unit

This block splits each nominal CAN bit into time quanta spread across four segments: a one-quantum synchronisation segment, a propagation segment, and two phase segments. It advances one quantum per cycle of a time-quantum enable. At the boundary between the two phase segments it samples the received line and raises a strobe. It watches the received line for falling (recessive-to-dominant) transitions. It measures how far each transition lies from the expected bit start and moves the next sample point by up to a programmable jump width.

A transition seen after the synchronisation quantum and up to the sample point is late, and the first phase segment grows to absorb it. A transition seen in the second phase segment is early. In that case the second phase segment shrinks, and the synchronisation quantum is dropped when the whole error can be absorbed. The unit treats a bit as running from one sample point to the next. It makes at most one correction in that span, and any correction lasts for one bit only. Short dominant spikes are filtered this way when the jump width covers their phase error.

Top module: `can_bit_resync`

## Requirements
- R1: While reset is asserted and right after it, `samplePulse` is 0 and `sampleBit` is 1 (recessive; the line encodes recessive as 1 and dominant as 0).
- R2: With no falling transition on `rxIn`, the quantum at the first `tqEn` after reset is quantum 0 and is the synchronisation quantum. Sample points then fall on quanta P+S1+m*N, where P, S1 and S2 are `propLen`, `ph1Len` and `ph2Len`, N = 1+P+S1+S2, and m = 0, 1, 2, and so on.
- R3: The unit advances only on cycles with `tqEn` high. `samplePulse` is high for exactly one clock, in the clock after the `tqEn` cycle of the last quantum of the first phase segment. Changes of `rxIn` while `tqEn` is low have no effect.
- R4: A falling transition first seen in a quantum j positions after the start of the synchronisation quantum (1 <= j <= P+S1) is late with error j. That bit's sample point moves later by min(j, SJW).
- R5: A falling transition first seen in the second phase segment, with r quanta of that segment left including the current one, is early with error r. The next sample point moves earlier by min(r, SJW). When r <= SJW, the quantum of the transition stands in for the synchronisation quantum.
- R6: A falling transition seen in the synchronisation quantum moves no sample point.
- R7: A rising (dominant-to-recessive) transition moves no sample point.
- R8: After a corrected bit, sample points again follow each other every N quanta.
- R9: Between two sample points only the first falling transition is used. Later ones in the same span are ignored.
- R10: A dominant spike that starts in the first quantum of the first phase segment and lasts P+S1 quanta is sampled as recessive when SJW >= P+1, and as dominant when SJW < P+1.
- R11: `sampleBit` takes the value of `rxIn` present in the `tqEn` cycle that produces the strobe, and holds it until the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tqEn | input | 1 | One-cycle time-quantum enable |
| propLen | input | LEN_W | Propagation segment length in quanta, at least 1 |
| ph1Len | input | LEN_W | First phase segment length in quanta, at least 1 |
| ph2Len | input | LEN_W | Second phase segment length in quanta, at least 1 |
| sjwLen | input | SJW_W | Jump width, from 1 up to min(4, ph1Len) |
| rxIn | input | 1 | Received bus level, 1 recessive, 0 dominant |
| samplePulse | output | 1 | One-clock strobe at each sample point |
| sampleBit | output | 1 | Bus level taken at the latest sample point |

## Verification
A single falling transition is swept across every quantum of the first two bits, for two segment layouts and every legal jump width. The sweep separates late, early and synchronisation-quantum transitions, and partial from full correction. It also shows that the bit after the correction returns to nominal length. Further patterns cover a lone rising transition (no effect), a second falling transition within one span (ignored while a fresh span accepts one), and a dominant spike whose fate depends on the jump width. `rxIn` is toggled between enables throughout, to show that only enabled cycles matter.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;

  typedef enum logic [1:0] {
    SEG_SYNC = 2'd0,
    SEG_PROP = 2'd1,
    SEG_PH1  = 2'd2,
    SEG_PH2  = 2'd3
  } segT;

  // strobes from control to datapath
  typedef struct packed {
    logic cntClr;     // restart quantum counter in next segment
    logic clrAdj;     // drop any stored lengthening or shortening
    logic ldLateProp; // store late correction measured in propagation segment
    logic ldLatePh1;  // store late correction measured in first phase segment
    logic ldCut;      // store partial early correction
    logic sampleNow;  // this quantum closes the first phase segment
  } ctlT;

  // status from datapath to control
  typedef struct packed {
    logic edgeSeen;   // falling transition in this enabled cycle
    logic propLast;
    logic ph1Last;
    logic ph2Last;
    logic ph2LastCut; // last quantum if second phase segment is cut by SJW
    logic earlyFull;  // early error fits within SJW
  } statT;

endpackage

// File: rtl/can_bt_dp.sv
module can_bt_dp
  import can_bt_pkg::*;
#(
  parameter int LEN_W = 4,
  parameter int SJW_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tqEn,
  input  logic             rxIn,
  input  logic [LEN_W-1:0] propLen,
  input  logic [LEN_W-1:0] ph1Len,
  input  logic [LEN_W-1:0] ph2Len,
  input  logic [SJW_W-1:0] sjwLen,
  input  ctlT              ctl,
  output statT             stat,
  output logic             samplePulse,
  output logic             sampleBit
);

  localparam int CNT_W = ((LEN_W + 1) > SJW_W) ? (LEN_W + 1) : SJW_W;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic             rxPrev;
  logic [CNT_W-1:0] cnt;
  logic [SJW_W-1:0] ph1Ext;
  logic [SJW_W-1:0] ph2Cut;

  logic [CNT_W-1:0] sjwW;
  logic [CNT_W-1:0] lateErrProp;
  logic [CNT_W-1:0] lateErrPh1;
  logic [CNT_W-1:0] earlyErr;

  function automatic logic [SJW_W-1:0] clampErr(input logic [CNT_W-1:0] err,
                                                input logic [CNT_W-1:0] lim,
                                                input logic [SJW_W-1:0] limNarrow);
    return (err > lim) ? limNarrow : err[SJW_W-1:0];
  endfunction

  always_comb begin
    sjwW        = CNT_W'(sjwLen);
    lateErrProp = cnt + ONE;
    lateErrPh1  = CNT_W'(propLen) + cnt + ONE;
    earlyErr    = CNT_W'(ph2Len) - cnt;

    stat.edgeSeen   = tqEn & rxPrev & ~rxIn;
    stat.propLast   = (cnt == CNT_W'(propLen) - ONE);
    stat.ph1Last    = (cnt == CNT_W'(ph1Len) + CNT_W'(ph1Ext) - ONE);
    stat.ph2Last    = (cnt == CNT_W'(ph2Len) - CNT_W'(ph2Cut) - ONE);
    stat.ph2LastCut = (cnt == CNT_W'(ph2Len) - sjwW - ONE);
    stat.earlyFull  = (earlyErr <= sjwW);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxPrev <= 1'b1;
      cnt    <= '0;
      ph1Ext <= '0;
      ph2Cut <= '0;
    end else if (tqEn) begin
      rxPrev <= rxIn;
      cnt    <= ctl.cntClr ? '0 : cnt + ONE;
      if (ctl.clrAdj) begin
        ph1Ext <= '0;
        ph2Cut <= '0;
      end else if (ctl.ldLateProp) begin
        ph1Ext <= clampErr(lateErrProp, sjwW, sjwLen);
      end else if (ctl.ldLatePh1) begin
        ph1Ext <= clampErr(lateErrPh1, sjwW, sjwLen);
      end else if (ctl.ldCut) begin
        ph2Cut <= sjwLen;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      samplePulse <= 1'b0;
      sampleBit   <= 1'b1;
    end else begin
      samplePulse <= tqEn & ctl.sampleNow;
      if (tqEn && ctl.sampleNow) begin
        sampleBit <= rxIn;
      end
    end
  end

endmodule

// File: rtl/can_bt_ctl.sv
module can_bt_ctl
  import can_bt_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic tqEn,
  input  statT stat,
  output ctlT  ctl,
  output segT  segNow
);

  segT  segNext;
  logic used;
  logic edgeOk;
  logic markUsed;

  assign edgeOk = stat.edgeSeen & ~used;

  always_comb begin
    ctl      = '0;
    segNext  = segNow;
    markUsed = 1'b0;
    if (tqEn) begin
      unique case (segNow)
        SEG_SYNC: begin
          // zero phase error: consume the resync, adjust nothing
          markUsed   = edgeOk;
          ctl.cntClr = 1'b1;
          ctl.clrAdj = 1'b1;
          segNext    = SEG_PROP;
        end
        SEG_PROP: begin
          if (edgeOk) begin
            markUsed       = 1'b1;
            ctl.ldLateProp = 1'b1;
          end
          if (stat.propLast) begin
            ctl.cntClr = 1'b1;
            segNext    = SEG_PH1;
          end
        end
        SEG_PH1: begin
          if (edgeOk) begin
            markUsed      = 1'b1;
            ctl.ldLatePh1 = 1'b1;
          end else if (stat.ph1Last) begin
            ctl.sampleNow = 1'b1;
            ctl.cntClr    = 1'b1;
            ctl.clrAdj    = 1'b1;
            segNext       = SEG_PH2;
          end
        end
        SEG_PH2: begin
          if (edgeOk) begin
            markUsed = 1'b1;
            if (stat.earlyFull) begin
              // this quantum acts as the synchronisation quantum
              ctl.cntClr = 1'b1;
              ctl.clrAdj = 1'b1;
              segNext    = SEG_PROP;
            end else begin
              ctl.ldCut = 1'b1;
              if (stat.ph2LastCut) begin
                ctl.cntClr = 1'b1;
                segNext    = SEG_SYNC;
              end
            end
          end else if (stat.ph2Last) begin
            ctl.cntClr = 1'b1;
            segNext    = SEG_SYNC;
          end
        end
        default: segNext = SEG_SYNC;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      segNow <= SEG_SYNC;
      used   <= 1'b0;
    end else if (tqEn) begin
      segNow <= segNext;
      if (ctl.sampleNow) begin
        used <= 1'b0;
      end else if (markUsed) begin
        used <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/can_bit_resync.sv
module can_bit_resync
  import can_bt_pkg::*;
#(
  parameter int LEN_W = 4,
  parameter int SJW_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tqEn,
  input  logic [LEN_W-1:0] propLen,
  input  logic [LEN_W-1:0] ph1Len,
  input  logic [LEN_W-1:0] ph2Len,
  input  logic [SJW_W-1:0] sjwLen,
  input  logic             rxIn,
  output logic             samplePulse,
  output logic             sampleBit
);

  ctlT  ctlBus;
  statT statBus;
  segT  segNow;

  can_bt_ctl i_ctl (
    .clk    (clk),
    .rstN   (rstN),
    .tqEn   (tqEn),
    .stat   (statBus),
    .ctl    (ctlBus),
    .segNow (segNow)
  );

  can_bt_dp #(
    .LEN_W (LEN_W),
    .SJW_W (SJW_W)
  ) i_dp (
    .clk         (clk),
    .rstN        (rstN),
    .tqEn        (tqEn),
    .rxIn        (rxIn),
    .propLen     (propLen),
    .ph1Len      (ph1Len),
    .ph2Len      (ph2Len),
    .sjwLen      (sjwLen),
    .ctl         (ctlBus),
    .stat        (statBus),
    .samplePulse (samplePulse),
    .sampleBit   (sampleBit)
  );

endmodule

// File: rtl/can_bit_resync_chk.sv
module can_bit_resync_chk
  import can_bt_pkg::*;
(
  input logic clk,
  input logic rstN,
  input logic tqEn,
  input logic rxIn,
  input logic samplePulse,
  input logic sampleBit,
  input segT  segNow
);

  // R3: strobe lasts one clock
  a_r3_one_clock: assert property (@(posedge clk) disable iff (!rstN)
    samplePulse |=> !samplePulse);

  // R3: strobe only follows an enabled cycle
  a_r3_after_tq: assert property (@(posedge clk) disable iff (!rstN)
    samplePulse |-> $past(tqEn));

  // R3: no progress without enable
  a_r3_hold_idle: assert property (@(posedge clk) disable iff (!rstN)
    !tqEn |=> $stable(segNow));

  // R2: synchronisation segment is one quantum
  a_r2_sync_one_tq: assert property (@(posedge clk) disable iff (!rstN)
    (tqEn && segNow == SEG_SYNC) |=> (segNow == SEG_PROP));

  // R2: sample point closes the first phase segment
  a_r2_from_ph1: assert property (@(posedge clk) disable iff (!rstN)
    samplePulse |-> ($past(segNow) == SEG_PH1 && segNow == SEG_PH2));

  // R11: sampled level matches the line in the enabled cycle
  a_r11_value: assert property (@(posedge clk) disable iff (!rstN)
    samplePulse |-> (sampleBit == $past(rxIn)));

  // R11: level held between strobes
  a_r11_hold: assert property (@(posedge clk) disable iff (!rstN)
    !samplePulse |-> $stable(sampleBit));

endmodule

bind can_bit_resync can_bit_resync_chk i_chk (
  .clk         (clk),
  .rstN        (rstN),
  .tqEn        (tqEn),
  .rxIn        (rxIn),
  .samplePulse (samplePulse),
  .sampleBit   (sampleBit),
  .segNow      (segNow)
);

// File: tb/test_can_bit_resync.sv
`timescale 1ns/1ps
module test_can_bit_resync;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tqEn = 1'b0;
  logic [3:0] propLen = 4'd2;
  logic [3:0] ph1Len = 4'd3;
  logic [3:0] ph2Len = 4'd3;
  logic [2:0] sjwLen = 3'd1;
  logic       rxIn = 1'b1;
  logic       samplePulse;
  logic       sampleBit;

  int  checks = 0;
  int  errors = 0;
  int  idleBad = 0;
  int  nSamp = 0;
  int  sampQ[8];
  bit  sampV[8];
  bit  wave[128];
  bit  done = 1'b0;

  always #5 clk = ~clk;

  can_bit_resync i_can_bit_resync (
    .clk         (clk),
    .rstN        (rstN),
    .tqEn        (tqEn),
    .propLen     (propLen),
    .ph1Len      (ph1Len),
    .ph2Len      (ph2Len),
    .sjwLen      (sjwLen),
    .rxIn        (rxIn),
    .samplePulse (samplePulse),
    .sampleBit   (sampleBit)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic doReset(input int p, input int s1, input int s2, input int sjw);
    @(negedge clk);
    rstN    = 1'b0;
    tqEn    = 1'b0;
    rxIn    = 1'b1;
    propLen = 4'(p);
    ph1Len  = 4'(s1);
    ph2Len  = 4'(s2);
    sjwLen  = 3'(sjw);
    repeat (2) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  // one quantum = one enabled clock plus two idle clocks with rxIn inverted
  task automatic runQuanta(input int n);
    nSamp   = 0;
    idleBad = 0;
    for (int q = 0; q < n; q++) begin
      @(negedge clk);
      rxIn = wave[q];
      tqEn = 1'b1;
      @(posedge clk);
      #1;
      if (samplePulse) begin
        if (nSamp < 8) begin
          sampQ[nSamp] = q;
          sampV[nSamp] = sampleBit;
        end
        nSamp++;
      end
      @(negedge clk);
      tqEn = 1'b0;
      rxIn = ~wave[q];
      @(posedge clk);
      #1;
      if (samplePulse) idleBad++;
      @(posedge clk);
      #1;
      if (samplePulse) idleBad++;
    end
    @(negedge clk);
    rxIn = 1'b1;
  endtask

  function automatic int minI(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  // expected quantum of sample idx for one falling transition at quantum t
  function automatic int expSamp(input int idx, input int t, input int p,
                                 input int s1, input int s2, input int sjw);
    int n = 1 + p + s1 + s2;
    int b = p + s1;
    if (t >= 1 && t <= b) return b + minI(t, sjw) + idx * n;       // late, bit 0
    if (t > b && t < n) return (idx == 0) ? b : b + idx * n - minI(n - t, sjw); // early
    if (t == n) return b + idx * n;                                // sync quantum
    return (idx == 0) ? b : b + idx * n + minI(t - n, sjw);        // late, bit 1
  endfunction

  function automatic string tagOf(input int t, input int p, input int s1, input int s2);
    int n = 1 + p + s1 + s2;
    if (t == n) return "R6 sync edge";
    if (t > p + s1 && t < n) return "R5 early edge";
    return "R4 late edge";
  endfunction

  initial begin
    #1_500_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int cp, cs1, cs2, n, b, e;

    // R1: reset state
    @(posedge clk);
    #1;
    check(samplePulse == 1'b0, "R1 pulse in reset", int'(samplePulse), 0);
    check(sampleBit == 1'b1, "R1 level in reset", int'(sampleBit), 1);
    doReset(2, 3, 3, 1);
    @(posedge clk);
    #1;
    check(samplePulse == 1'b0 && sampleBit == 1'b1, "R1 after release",
          int'({samplePulse, sampleBit}), 1);

    // R2: no edges, nominal spacing
    for (int q = 0; q < 128; q++) wave[q] = 1'b1;
    doReset(2, 3, 3, 2);
    runQuanta(50);
    check(nSamp >= 5, "R2 sample count", nSamp, 5);
    for (int i = 0; i < 5; i++) begin
      check(sampQ[i] == 5 + i * 9, "R2 nominal sample point", sampQ[i], 5 + i * 9);
      check(sampV[i] == 1'b1, "R11 recessive value", int'(sampV[i]), 1);
    end
    check(idleBad == 0, "R3 pulse on idle clock", idleBad, 0);

    // R4 R5 R6 R8 R11: single falling transition swept over two bits
    for (int cfg = 0; cfg < 2; cfg++) begin
      cp  = (cfg == 0) ? 2 : 1;
      cs1 = (cfg == 0) ? 3 : 4;
      cs2 = (cfg == 0) ? 3 : 2;
      n   = 1 + cp + cs1 + cs2;
      b   = cp + cs1;
      for (int sjw = 1; sjw <= minI(4, cs1); sjw++) begin
        for (int t = 1; t <= n + b; t++) begin
          for (int q = 0; q < 128; q++) wave[q] = (q < t);
          doReset(cp, cs1, cs2, sjw);
          runQuanta(5 * n);
          check(nSamp >= 3, "R2 sample count", nSamp, 3);
          for (int idx = 0; idx < 3; idx++) begin
            e = expSamp(idx, t, cp, cs1, cs2, sjw);
            check(sampQ[idx] == e, (idx == 2) ? "R8 back to nominal" : tagOf(t, cp, cs1, cs2),
                  sampQ[idx], e);
            check(sampV[idx] == (e < t), "R11 sampled level", int'(sampV[idx]), int'(e < t));
          end
          check(idleBad == 0, "R3 pulse on idle clock", idleBad, 0);
        end
      end
    end

    // R7: only a rising transition (line dominant from quantum 0 up to 10)
    for (int q = 0; q < 128; q++) wave[q] = (q >= 10);
    doReset(2, 3, 3, 3);
    runQuanta(40);
    check(sampQ[0] == 5, "R7 first sample", sampQ[0], 5);
    check(sampQ[1] == 14, "R7 rising edge ignored", sampQ[1], 14);
    check(sampQ[2] == 23, "R7 rising edge ignored", sampQ[2], 23);
    check(sampV[0] == 1'b0 && sampV[1] == 1'b1, "R11 levels around rise",
          int'({sampV[0], sampV[1]}), 1);

    // R9: second falling transition in one span ignored, fresh span accepts one
    for (int q = 0; q < 128; q++) wave[q] = 1'b1;
    for (int q = 10; q < 128; q++) wave[q] = 1'b0;
    wave[11] = 1'b1;
    wave[16] = 1'b1;
    doReset(2, 3, 3, 3);
    runQuanta(40);
    check(sampQ[1] == 15, "R9 second edge ignored", sampQ[1], 15);
    check(sampQ[2] == 22, "R9 next span resyncs early", sampQ[2], 22);
    check(sampQ[3] == 31, "R8 spacing after early", sampQ[3], 31);
    check(sampV[1] == 1'b0, "R11 dominant level", int'(sampV[1]), 0);

    // R10: dominant spike of P+S1 quanta from first quantum of phase segment 1
    for (int sjw = 1; sjw <= 2; sjw++) begin
      for (int q = 0; q < 128; q++) wave[q] = !(q >= 9 && q <= 12);
      doReset(1, 3, 2, sjw);
      runQuanta(30);
      check(sampQ[1] == 11 + sjw, "R10 spike sample point", sampQ[1], 11 + sjw);
      check(sampV[1] == (sjw >= 2), "R10 spike filtering", int'(sampV[1]), int'(sjw >= 2));
      check(sampQ[2] == 18 + sjw, "R7 trailing rise ignored", sampQ[2], 18 + sjw);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule